// File: doc/BRIEF.md
# ADC Result Stability Filter

This block watches a stream of analog-to-digital conversion results and decides when a result is trustworthy enough to publish in a status register. Each conversion arrives as an 8-bit word qualified by a one-cycle valid strobe. In filtered mode, a result is published only after a run of consecutive conversions agree on their upper bits, so noise in the lowest bits does not cause the published value to flicker. In bypass mode, every conversion is published as soon as it arrives.

The block also owns the converter's input-source selection. A select bit chooses between the on-chip temperature sensor and an external sense pin, and the block drives the registered choice onto a mux-select output. A change of source discards all agreement history, so samples from the two sources never count toward the same run. Each time the status register loads, the block raises a one-cycle update strobe. A consumer can use it as an interrupt or as a capture enable.

Top module: `adc_stab_filter`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `status_o` is 0, `status_upd_o` is 0 and `mux_sel_o` is 0. Agreement history is empty.
- R2: With `filt_bypass_i` = 1, each cycle with `conv_valid_i` = 1 loads the full 8-bit `conv_data_i` into `status_o`. `status_upd_o` is 1 in the following cycle.
- R3: With `filt_bypass_i` = 0, `status_o` loads only when the current result is the 4th consecutive result whose bits [7:2] equal those of the previous result. The value loaded is the full 8-bit value of that 4th result.
- R4: Bits [1:0] of a result take no part in the agreement test. Results that differ only there still count as agreeing.
- R5: A result whose bits [7:2] differ from the previous result restarts the run at a count of one.
- R6: After a filtered load the run count restarts at zero. With a stable input, the status therefore loads again on every 4th further agreeing result.
- R7: `mux_sel_o` equals `src_sel_i` delayed by one clock. A value of 0 selects the temperature sensor and 1 selects the external sense pin.
- R8: In a cycle where `src_sel_i` differs from `mux_sel_o`, the agreement history is cleared. A conversion in that same cycle is not counted. After the change, four fresh agreeing results are needed for a filtered load.
- R9: `status_upd_o` is high for exactly one cycle per load. `status_o` does not change in any cycle where `status_upd_o` is 0.
- R10: In cycles with `conv_valid_i` = 0, the value on `conv_data_i` affects neither the status nor the history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| conv_valid_i | input | 1 | One-cycle strobe marking a finished conversion |
| conv_data_i | input | 8 | Conversion result |
| filt_bypass_i | input | 1 | 1: publish every result; 0: publish after agreement |
| src_sel_i | input | 1 | Converter source: 0 temperature sensor, 1 external pin |
| mux_sel_o | output | 1 | Registered source select to the analog mux |
| status_o | output | 8 | Published conversion result |
| status_upd_o | output | 1 | One-cycle pulse on each status load |

## Verification
A corrupted run counter or reference value never shows up on the ports directly. It becomes visible only as a status load that arrives one or more conversions early or late. A test therefore checks the strobe and the status after every single conversion, not just at the end of a run. A missed history clear on a source change shows up within the next three conversions, as a premature load. A broken bypass path or a broken strobe shows up in the cycle right after the offending conversion.

// File: rtl/adc_flt_pkg.sv
package adc_flt_pkg;

    localparam int unsigned DATA_W  = 8;
    localparam int unsigned CMP_W   = 6;
    localparam int unsigned MATCH_N = 4;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              upd;
    } status_state_t;

endpackage

// File: rtl/adc_flt_match.sv
module adc_flt_match #(
    parameter int unsigned CMP_W   = 6,
    parameter int unsigned MATCH_N = 4,
    localparam int unsigned CNT_W  = $clog2(MATCH_N + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             sample_i,
    input  logic [CMP_W-1:0] top_i,
    input  logic             clear_i,
    output logic             hit_o,
    output logic [CNT_W-1:0] cnt_o
);

    typedef struct packed {
        logic [CMP_W-1:0] ref_bits;
        logic             have_ref;
        logic [CNT_W-1:0] cnt;
    } match_state_t;

    match_state_t st_d, st_q;
    logic [CNT_W-1:0] run_len;
    logic             agree;

    always_comb begin
        st_d    = st_q;
        hit_o   = 1'b0;
        agree   = st_q.have_ref && (top_i == st_q.ref_bits);
        run_len = agree ? st_q.cnt + 1'b1 : CNT_W'(1);
        if (clear_i) begin
            st_d.have_ref = 1'b0;
            st_d.cnt      = '0;
        end else if (sample_i) begin
            st_d.ref_bits = top_i;
            st_d.have_ref = 1'b1;
            if (run_len == CNT_W'(MATCH_N)) begin
                hit_o    = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = run_len;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

endmodule

// File: rtl/adc_flt_status.sv
module adc_flt_status
    import adc_flt_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] value_o,
    output logic              upd_o
);

    status_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.upd = load_i;
        if (load_i) st_d.value = data_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign value_o = st_q.value;
    assign upd_o   = st_q.upd;

endmodule

// File: rtl/adc_stab_filter.sv
module adc_stab_filter
    import adc_flt_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              conv_valid_i,
    input  logic [DATA_W-1:0] conv_data_i,
    input  logic              filt_bypass_i,
    input  logic              src_sel_i,
    output logic              mux_sel_o,
    output logic [DATA_W-1:0] status_o,
    output logic              status_upd_o
);

    localparam int unsigned CNT_W = $clog2(MATCH_N + 1);

    logic             src_d, src_q;
    logic             src_change;
    logic             match_hit;
    logic [CNT_W-1:0] match_cnt;
    logic             load;

    always_comb begin
        src_change = (src_sel_i != src_q);
        src_d      = src_sel_i;
        load       = conv_valid_i && (filt_bypass_i || match_hit);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) src_q <= 1'b0;
        else         src_q <= src_d;
    end

    adc_flt_match #(
        .CMP_W  (CMP_W),
        .MATCH_N(MATCH_N)
    ) u_match (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .sample_i(conv_valid_i),
        .top_i   (conv_data_i[DATA_W-1 -: CMP_W]),
        .clear_i (src_change),
        .hit_o   (match_hit),
        .cnt_o   (match_cnt)
    );

    adc_flt_status u_status (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (load),
        .data_i (conv_data_i),
        .value_o(status_o),
        .upd_o  (status_upd_o)
    );

    assign mux_sel_o = src_q;

endmodule

// File: rtl/adc_stab_filter_chk.sv
module adc_stab_filter_chk
    import adc_flt_pkg::*;
#(
    parameter int unsigned CNT_W = 3
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              conv_valid_i,
    input logic [DATA_W-1:0] conv_data_i,
    input logic              filt_bypass_i,
    input logic              src_sel_i,
    input logic              mux_sel_o,
    input logic [DATA_W-1:0] status_o,
    input logic              status_upd_o,
    input logic              match_hit,
    input logic [CNT_W-1:0]  match_cnt
);

    assert_reset_clear_R1: assert property (@(posedge clk_i)
        $rose(rst_ni) |-> (status_o == '0 && !status_upd_o && !mux_sel_o));

    assert_bypass_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (conv_valid_i && filt_bypass_i) |=> (status_upd_o && status_o == $past(conv_data_i)));

    assert_filter_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (conv_valid_i && !filt_bypass_i) |=> (status_upd_o == $past(match_hit)));

    assert_cnt_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        match_cnt < CNT_W'(MATCH_N));

    assert_mux_follow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> (mux_sel_o == $past(src_sel_i)));

    assert_no_silent_change_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !status_upd_o |-> $stable(status_o));

    assert_strobe_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_upd_o && $past(rst_ni)) |-> $past(conv_valid_i));

endmodule

bind adc_stab_filter adc_stab_filter_chk #(
    .CNT_W($clog2(adc_flt_pkg::MATCH_N + 1))
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .conv_valid_i (conv_valid_i),
    .conv_data_i  (conv_data_i),
    .filt_bypass_i(filt_bypass_i),
    .src_sel_i    (src_sel_i),
    .mux_sel_o    (mux_sel_o),
    .status_o     (status_o),
    .status_upd_o (status_upd_o),
    .match_hit    (match_hit),
    .match_cnt    (match_cnt)
);

// File: tb/adc_stab_filter_bench.sv
module adc_stab_filter_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       valid = 1'b0;
    logic [7:0] data = '0;
    logic       bypass = 1'b0;
    logic       src = 1'b0;
    logic       mux_sel;
    logic [7:0] status;
    logic       upd;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    adc_stab_filter u_adc_stab_filter (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .conv_valid_i (valid),
        .conv_data_i  (data),
        .filt_bypass_i(bypass),
        .src_sel_i    (src),
        .mux_sel_o    (mux_sel),
        .status_o     (status),
        .status_upd_o (upd)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        valid = 1'b0;
        src   = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // one conversion; returns at the next falling edge, outputs already updated
    task automatic conv(input logic [7:0] d);
        data  = d;
        valid = 1'b1;
        @(negedge clk);
        valid = 1'b0;
    endtask

    task automatic conv_expect_none(input string req, input logic [7:0] d, input logic [7:0] held);
        conv(d);
        check(req, upd, 0);
        check(req, status, held);
    endtask

    task automatic conv_expect_load(input string req, input logic [7:0] d);
        conv(d);
        check(req, upd, 1);
        check(req, status, d);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        src   = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 status", status, 0);
        check("R1 upd", upd, 0);
        check("R1 mux", mux_sel, 0);
        rst_n = 1'b1;
        src   = 1'b0;
        @(negedge clk);
        check("R1 status after release", status, 0);
        check("R1 mux after release", mux_sel, 0);
    endtask

    task automatic t_bypass();
        do_reset();
        bypass = 1'b1;
        conv_expect_load("R2 first", 8'h12);
        conv_expect_load("R2 second", 8'hA7);
        conv_expect_load("R2 same top bits", 8'hA4);
        check("R9 one-cycle strobe", upd, 1);
        @(negedge clk);
        check("R9 strobe drops", upd, 0);
        check("R9 status held", status, 8'hA4);
        // R10: data wiggles without valid
        for (int i = 0; i < 5; i++) begin
            data = 8'(8'h3C + i * 8'h11);
            @(negedge clk);
            check("R10 ignored data upd", upd, 0);
            check("R10 ignored data status", status, 8'hA4);
        end
        bypass = 1'b0;
    endtask

    task automatic t_filter_basic();
        do_reset();
        for (int i = 0; i < 3; i++) conv_expect_none("R3 waiting", 8'h80, 8'h00);
        conv_expect_load("R3 fourth agreeing", 8'h80);
        @(negedge clk);
        check("R9 strobe single", upd, 0);
    endtask

    task automatic t_lsb();
        do_reset();
        conv_expect_none("R4 lsb 0", 8'h40, 8'h00);
        conv_expect_none("R4 lsb 1", 8'h41, 8'h00);
        conv_expect_none("R4 lsb 2", 8'h42, 8'h00);
        conv_expect_load("R4 lsb 3 loads full", 8'h43);
    endtask

    task automatic t_restart();
        do_reset();
        for (int i = 0; i < 3; i++) conv_expect_none("R5 first run", 8'h10, 8'h00);
        for (int i = 0; i < 3; i++) conv_expect_none("R5 new run", 8'h20, 8'h00);
        conv_expect_load("R5 restarted run", 8'h20);
        // a gap without valid does not break the run (R10)
        conv_expect_none("R10 gap a", 8'h21, 8'h20);
        @(negedge clk);
        data = 8'hFF;
        @(negedge clk);
        conv_expect_none("R10 gap b", 8'h22, 8'h20);
        conv_expect_none("R10 gap c", 8'h23, 8'h20);
        conv_expect_load("R10 gap load", 8'h20);
    endtask

    task automatic t_repeat();
        do_reset();
        for (int i = 0; i < 3; i++) conv_expect_none("R6 lead", 8'h55, 8'h00);
        conv_expect_load("R6 first load", 8'h55);
        conv_expect_none("R6 after load 1", 8'h56, 8'h55);
        conv_expect_none("R6 after load 2", 8'h57, 8'h55);
        conv_expect_none("R6 after load 3", 8'h54, 8'h55);
        conv_expect_load("R6 second load", 8'h57);
    endtask

    task automatic t_source();
        do_reset();
        for (int i = 0; i < 3; i++) conv_expect_none("R8 pre switch", 8'h30, 8'h00);
        src = 1'b1;
        check("R7 mux not yet", mux_sel, 0);
        @(negedge clk);
        check("R7 mux follows", mux_sel, 1);
        for (int i = 0; i < 3; i++) conv_expect_none("R8 history cleared", 8'h30, 8'h00);
        conv_expect_load("R8 fresh run loads", 8'h31);
        // conversion coincident with a switch is not counted
        for (int i = 0; i < 3; i++) conv_expect_none("R8 run b", 8'h70, 8'h31);
        src = 1'b0;
        conv_expect_none("R8 coincident sample", 8'h70, 8'h31);
        check("R7 mux back to 0", mux_sel, 0);
        for (int i = 0; i < 3; i++) conv_expect_none("R8 after coincident", 8'h70, 8'h31);
        conv_expect_load("R8 coincident not counted", 8'h72);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_bypass();
        t_filter_basic();
        t_lsb();
        t_restart();
        t_repeat();
        t_source();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule